// File: doc/BRIEF.md
# Status Monitor Interrupt Unit

This unit watches twelve handshake lines coming from a programmable fabric and turns their activity into a single interrupt. Software controls it through a small register window. Each line first passes through a two-flop synchronizer. A per-line type bit then selects level or edge detection, and a per-line polarity bit chooses which level or edge counts as active. In edge mode an event latches and holds until software clears it.

Software can read the synchronized line values directly, or it can read the raw and qualified event status. The qualified status keeps only the lines that are enabled and not masked. Writing ones to the clear register acknowledges latched edge events. The interrupt output is high whenever any qualified status bit is set. What each line means is left to the surrounding logic; the unit only deals in bit positions.

Top module: `mon_irq_unit`

## Requirements
- R1: A read of the line-value register (offset 0x850) returns each input after exactly two clock edges of synchronization, in bits [11:0], with bits [31:12] zero.
- R2: With the type bit at 0 (level), the raw status bit (offset 0x844) equals the synchronized input when the polarity bit is 1, and its inverse when the polarity bit is 0.
- R3: With the type bit at 1 (edge), the raw status bit sets one edge after the synchronized input makes an active transition (0 to 1 for polarity 1, 1 to 0 for polarity 0), and then holds whatever the input does.
- R4: Writing to the clear register (offset 0x84C) clears each latched edge bit whose write-data bit is 1 and leaves bits written 0 untouched; an edge arriving in the same cycle as its clear wins, so the bit stays set.
- R5: A clear write has no lasting effect on a bit in level mode: its raw status still follows the active level.
- R6: The qualified status (offset 0x840) equals the raw status ANDed with the enable register (offset 0x830) and with the inverse of the mask register (offset 0x834).
- R7: The interrupt output is high exactly when any qualified status bit is 1.
- R8: After reset the enable, mask, type (offset 0x838) and polarity (offset 0x83C) registers and the line values read 0, the raw status reads 0xFFF (every line level-sensitive and active low with its synchronizer at 0), and the interrupt is low.
- R9: The enable, mask, type and polarity registers store bits [11:0] of the write data and read back with bits [31:12] zero; the clear register and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_in | input | 12 | Asynchronous monitored lines |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_addr | input | 12 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench aims at the set-versus-clear collision in edge mode: a design that let the clear win would drop an event that arrived in the acknowledge cycle, leaving an interrupt lost. It also flips polarity and type while lines are busy, so a design that compared the previous sample under a different polarity would latch false edges, and one that gated raw status by the enable would disagree in the raw register. Clear writes aimed at level-mode bits catch a design that latches level events and so keeps an interrupt asserted, or lowers it, after the line has changed.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;
  localparam int          MON_W   = 12;
  localparam int          ADDR_W  = 12;
  localparam int          DATA_W  = 32;
  localparam logic [11:0] OFS_EN   = 12'h830;
  localparam logic [11:0] OFS_MSK  = 12'h834;
  localparam logic [11:0] OFS_TYP  = 12'h838;
  localparam logic [11:0] OFS_POL  = 12'h83C;
  localparam logic [11:0] OFS_QUAL = 12'h840;
  localparam logic [11:0] OFS_RAW  = 12'h844;
  localparam logic [11:0] OFS_CLR  = 12'h84C;
  localparam logic [11:0] OFS_LINE = 12'h850;
endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic stg1_q, stg2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg1_q <= 1'b0;
        stg2_q <= 1'b0;
      end else begin
        stg1_q <= async_in[g];
        stg2_q <= stg1_q;
      end
    end
    assign sync_out[g] = stg2_q;
  end
endmodule

// File: rtl/mon_detect.sv
module mon_detect #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_s,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] raw_stat,
  output logic [W-1:0] edge_latch
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic prev_q, hold_q, hold_d, act_now, act_prev, hit;

    // previous sample is judged with the current polarity, so a polarity
    // change alone never looks like an edge
    assign act_now  = pol[g] ? line_s[g] : ~line_s[g];
    assign act_prev = pol[g] ? prev_q    : ~prev_q;
    assign hit      = edge_sel[g] & act_now & ~act_prev;

    always_comb begin
      hold_d = hold_q & ~clr_vec[g];
      if (hit) hold_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        prev_q <= line_s[g];
        hold_q <= hold_d;
      end
    end

    assign raw_stat[g]   = edge_sel[g] ? hold_q : act_now;
    assign edge_latch[g] = hold_q;
  end
endmodule

// File: rtl/mon_regs.sv
module mon_regs
  import mon_irq_pkg::*;
#(
  parameter int W  = 12,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [W-1:0]      line_s,
  input  logic [W-1:0]      raw_stat,
  output logic [DW-1:0]     reg_rdata,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      msk_q,
  output logic [W-1:0]      typ_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      clr_vec,
  output logic [W-1:0]      qual_stat
);
  logic          en_we, msk_we, typ_we, pol_we;
  logic [W-1:0]  en_d, msk_d, typ_d, pol_d, wbits;

  assign wbits  = reg_wdata[W-1:0];
  assign en_we  = reg_wr && (reg_addr == OFS_EN);
  assign msk_we = reg_wr && (reg_addr == OFS_MSK);
  assign typ_we = reg_wr && (reg_addr == OFS_TYP);
  assign pol_we = reg_wr && (reg_addr == OFS_POL);
  assign clr_vec = (reg_wr && (reg_addr == OFS_CLR)) ? wbits : '0;

  always_comb begin
    en_d  = en_we  ? wbits : en_q;
    msk_d = msk_we ? wbits : msk_q;
    typ_d = typ_we ? wbits : typ_q;
    pol_d = pol_we ? wbits : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
      typ_q <= '0;
      pol_q <= '0;
    end else begin
      en_q  <= en_d;
      msk_q <= msk_d;
      typ_q <= typ_d;
      pol_q <= pol_d;
    end
  end

  assign qual_stat = raw_stat & en_q & ~msk_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_EN:   reg_rdata[W-1:0] = en_q;
      OFS_MSK:  reg_rdata[W-1:0] = msk_q;
      OFS_TYP:  reg_rdata[W-1:0] = typ_q;
      OFS_POL:  reg_rdata[W-1:0] = pol_q;
      OFS_QUAL: reg_rdata[W-1:0] = qual_stat;
      OFS_RAW:  reg_rdata[W-1:0] = raw_stat;
      OFS_LINE: reg_rdata[W-1:0] = line_s;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mon_irq_unit.sv
module mon_irq_unit
  import mon_irq_pkg::*;
#(
  parameter int N_MON = MON_W,
  parameter int DW    = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MON-1:0]  mon_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_out
);
  logic [N_MON-1:0] line_s, raw_w, latch_w, en_w, msk_w, typ_w, pol_w, clr_w, qual_w;

  mon_sync #(.W(N_MON)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mon_in), .sync_out(line_s)
  );

  mon_detect #(.W(N_MON)) u_det (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .pol(pol_w), .edge_sel(typ_w),
    .clr_vec(clr_w), .raw_stat(raw_w), .edge_latch(latch_w)
  );

  mon_regs #(.W(N_MON), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .line_s(line_s), .raw_stat(raw_w),
    .reg_rdata(reg_rdata), .en_q(en_w), .msk_q(msk_w), .typ_q(typ_w),
    .pol_q(pol_w), .clr_vec(clr_w), .qual_stat(qual_w)
  );

  assign irq_out = |qual_w;
endmodule

// File: rtl/mon_irq_chk.sv
module mon_irq_chk #(
  parameter int N  = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_out,
  input logic [N-1:0]  raw_stat,
  input logic [N-1:0]  qual_stat,
  input logic [N-1:0]  edge_latch,
  input logic [N-1:0]  clr_vec,
  input logic [N-1:0]  en_vec
);
  // R6: qualified bits come only from raw, enabled lines
  a_r6_qual_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((qual_stat & ~raw_stat) == '0) && ((qual_stat & ~en_vec) == '0));

  // R7: any qualified bit raises the interrupt
  a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_stat != '0) |-> irq_out);

  // R7: no interrupt with every line disabled
  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en_vec != '0));

  // R3, R4: a latched event survives unless its clear bit was written
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_latch) & ~$past(clr_vec)) & ~edge_latch) == '0));

  // R9: read data above the line width is always zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:N] == '0);
endmodule

bind mon_irq_unit mon_irq_chk #(.N(N_MON), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .raw_stat(raw_w), .qual_stat(qual_w), .edge_latch(latch_w),
  .clr_vec(clr_w), .en_vec(en_w)
);

// File: tb/mon_irq_unit_tb.sv
`timescale 1ns/1ps
module mon_irq_unit_tb;
  import mon_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mon_in;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;

  logic [11:0] m_s1, m_s2, m_prev, m_lat, m_en, m_msk, m_typ, m_pol;

  always #2 clk = ~clk;

  mon_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mon_in(mon_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [11:0] act(input logic [11:0] v, input logic [11:0] p);
    return ~(v ^ p);
  endfunction

  function automatic logic [11:0] exp_raw();
    return (m_typ & m_lat) | (~m_typ & act(m_s2, m_pol));
  endfunction

  function automatic logic [11:0] exp_qual();
    return exp_raw() & m_en & ~m_msk;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag, input logic [31:0] exp);
    reg_addr = a;
    #0.1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic check_all();
    rd_chk(OFS_LINE, "R1 line value",     {20'd0, m_s2});
    rd_chk(OFS_RAW,  "R2 R3 raw status",  {20'd0, exp_raw()});
    rd_chk(OFS_QUAL, "R6 qualified",      {20'd0, exp_qual()});
    rd_chk(OFS_EN,   "R9 enable",         {20'd0, m_en});
    rd_chk(OFS_MSK,  "R9 mask",           {20'd0, m_msk});
    rd_chk(OFS_TYP,  "R9 type",           {20'd0, m_typ});
    rd_chk(OFS_POL,  "R9 polarity",       {20'd0, m_pol});
    chk("R7 irq", {31'd0, irq_out}, {31'd0, |exp_qual()});
  endtask

  // one clock edge; the model uses the values driven before the edge
  task automatic tick();
    logic [11:0] clr, hit;
    @(posedge clk);
    clr = (reg_wr && reg_addr == OFS_CLR) ? reg_wdata[11:0] : 12'd0;
    hit = m_typ & act(m_s2, m_pol) & ~act(m_prev, m_pol);
    m_lat  = hit | (m_lat & ~clr);
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = mon_in;
    if (reg_wr) begin
      case (reg_addr)
        OFS_EN:  m_en  = reg_wdata[11:0];
        OFS_MSK: m_msk = reg_wdata[11:0];
        OFS_TYP: m_typ = reg_wdata[11:0];
        OFS_POL: m_pol = reg_wdata[11:0];
        default: ;
      endcase
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
  endtask

  initial begin
    #(4.0 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] pick;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; mon_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    {m_s1, m_s2, m_prev, m_lat, m_en, m_msk, m_typ, m_pol} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd_chk(OFS_RAW,  "R8 raw after reset", 32'h0000_0FFF);
    rd_chk(OFS_LINE, "R8 lines after reset", 32'h0);
    rd_chk(OFS_EN,   "R8 enable after reset", 32'h0);
    chk("R8 irq after reset", {31'd0, irq_out}, 32'd0);

    // R9 width and write-only / unmapped reads
    wr_reg(OFS_EN, 32'hFFFF_FFFF);
    rd_chk(OFS_EN,  "R9 enable width", 32'h0000_0FFF);
    rd_chk(OFS_CLR, "R9 clear reads zero", 32'h0);
    rd_chk(12'h000, "R9 unmapped reads zero", 32'h0);

    // R2 level, active high; R1 two-edge latency
    wr_reg(OFS_POL, 32'h0000_0FFF);
    mon_in = 12'h001;
    tick();
    rd_chk(OFS_LINE, "R1 not yet visible after one edge", 32'h0);
    tick();
    rd_chk(OFS_LINE, "R1 visible after two edges", 32'h001);
    rd_chk(OFS_RAW,  "R2 level active high", 32'h001);
    chk("R7 irq from level", {31'd0, irq_out}, 32'd1);
    // R5 clear on a level bit
    wr_reg(OFS_CLR, 32'h0000_0001);
    rd_chk(OFS_RAW, "R5 level ignores clear", 32'h001);
    // R6 mask hides the bit
    wr_reg(OFS_MSK, 32'h0000_0001);
    rd_chk(OFS_QUAL, "R6 masked bit hidden", 32'h0);
    chk("R7 irq low when masked", {31'd0, irq_out}, 32'd0);
    wr_reg(OFS_MSK, 32'h0);

    // R3 edge, active high on bit 1
    wr_reg(OFS_TYP, 32'h0000_0002);
    mon_in = 12'h003;
    tick(); tick();
    rd_chk(OFS_RAW, "R3 not latched before detect edge", 32'h001);
    tick();
    rd_chk(OFS_RAW, "R3 edge latched", 32'h003);
    mon_in = 12'h001;
    repeat (3) tick();
    rd_chk(OFS_RAW, "R3 latch holds after input falls", 32'h003);
    wr_reg(OFS_CLR, 32'h0000_0FFC);
    rd_chk(OFS_RAW, "R4 zero clear bit leaves latch", 32'h003);
    wr_reg(OFS_CLR, 32'h0000_0002);
    rd_chk(OFS_RAW, "R4 clear drops latch", 32'h001);

    // R4 collision: edge detected in the clear cycle stays set
    mon_in = 12'h003;
    tick();
    tick();
    wr_reg(OFS_CLR, 32'h0000_0002);
    rd_chk(OFS_RAW, "R4 set wins over clear", 32'h003);
    check_all();

    // constrained random with model comparison
    for (int i = 0; i < 3000; i++) begin
      check_all();
      if ($urandom_range(0, 3) == 0) mon_in = 12'($urandom());
      else if ($urandom_range(0, 1) == 0) mon_in = mon_in ^ (12'd1 << $urandom_range(0, 11));
      if ($urandom_range(0, 2) == 0) begin
        pick = 12'($urandom_range(0, 4));
        case (pick)
          12'd0: reg_addr = OFS_EN;
          12'd1: reg_addr = OFS_MSK;
          12'd2: reg_addr = OFS_TYP;
          12'd3: reg_addr = OFS_POL;
          default: reg_addr = OFS_CLR;
        endcase
        reg_wdata = $urandom();
        reg_wr    = 1'b1;
      end
      tick();
    end
    check_all();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule